// File: doc/BRIEF.md
# Unified Multi-Size Translation Buffer

This block is a small fully associative translation cache in which every slot can hold a page or block of any supported size. A translation request carries a virtual address. One cycle later the block answers with a hit flag, the composed physical address and the permission bits stored with the matching slot. Each slot keeps an aligned tag, an aligned physical frame and its own offset mask. The mask removes the bits below the page size from the tag compare, and the same mask selects which virtual address bits pass straight through into the physical address. All sizes are therefore matched in the same cycle against one shared array.

A fill port accepts a leaf descriptor from an external table walker:
- the virtual and physical addresses;
- the permissions;
- the granule (4 KB or 16 KB);
- the walk level;
- the contiguous hint flag.

When the hint is set and the `HINT_EN` parameter allows it, the block widens the slot to cover the whole run of neighbouring descriptors. It aligns the tag and the frame down to the boundary of that enlarged region. A flush input empties the whole array in one cycle. Slots are replaced round-robin.

Top module: `tlb_unified`

## Requirements
- R1: After reset no slot is valid: every request answers with `resp_valid` set and `resp_hit` low, and `resp_valid`, `resp_hit` and `resp_multi` read 0 while reset is held.
- R2: A request accepted on a clock edge is answered on the next edge (`resp_valid` = the previous `lookup_req`). `resp_hit` and `resp_multi` are low whenever `resp_valid` is low.
- R3: With `fill_gran16k`=0, `fill_level` 3, 2 and 1 give 4 KB, 2 MB and 1 GB mappings. On a hit, `resp_pa` is the aligned frame OR the virtual address bits below the mapping size.
- R4: With `fill_gran16k`=1, `fill_level` 3 and 2 give 16 KB and 32 MB mappings.
- R5: With the 4 KB granule and `fill_contig`=1, the mapping covers 16 times the descriptor size. Its tag and frame are aligned down to that enlarged size.
- R6: With the 16 KB granule and `fill_contig`=1, the mapping covers 32 times the descriptor size, so a 32 MB descriptor yields a 1 GB mapping.
- R7: With `HINT_EN`=0, `fill_contig` is ignored and only the descriptor's own size is mapped.
- R8: Fills with an unsupported granule/level pair (level 0, or level 1 with the 16 KB granule) change nothing and consume no slot.
- R9: A fill whose aligned tag and size equal those of a valid slot overwrites that slot in place, without using a new slot.
- R10: If a request matches more than one slot, `resp_multi` is set and the data of the lowest-index matching slot is returned.
- R11: New fills take slots round-robin, starting at slot 0 after reset or flush. With `ENTRIES` slots, fill number `ENTRIES`+1 evicts the first one.
- R12: `flush` invalidates every slot at the next edge, and it wins over a fill in the same cycle.
- R13: A request and a fill in the same cycle: the request sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every slot |
| fill_req | input | 1 | Fill strobe |
| fill_va | input | VA_W | Descriptor virtual address |
| fill_pa | input | PA_W | Descriptor physical address |
| fill_perm | input | PERM_W | Permission bits to store |
| fill_gran16k | input | 1 | Granule: 0 = 4 KB, 1 = 16 KB |
| fill_level | input | 2 | Walk level of the leaf (1, 2 or 3) |
| fill_contig | input | 1 | Contiguous hint from the descriptor |
| lookup_req | input | 1 | Translation request strobe |
| lookup_va | input | VA_W | Virtual address to translate |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_hit | output | 1 | Translation found |
| resp_multi | output | 1 | More than one slot matched |
| resp_pa | output | PA_W | Composed physical address |
| resp_perm | output | PERM_W | Stored permissions of the selected slot |

## Verification
The assertions check on every cycle the behaviours that need no knowledge of the array's contents:
- the one-cycle answer timing;
- quiet hit and multi flags when there is no response;
- a multi-match is always reported together with a hit;
- the low 12 address bits always pass through on a hit;
- no hit from a request made right after a flush.

Only the bench's scenarios can show the behaviours that depend on what was filled earlier: each size decoding, widening and alignment under the hint, the in-place overwrite, the lowest-index choice, the round-robin eviction order, the ignored illegal fills and the ignored hint with `HINT_EN`=0.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int SHIFT_W = 6;
  localparam logic GRAN_4K  = 1'b0;
  localparam logic GRAN_16K = 1'b1;

  typedef struct packed {
    logic               legal;
    logic [SHIFT_W-1:0] shift;
  } size_sel_t;

  // log2 of the mapped region for a leaf descriptor; widen applies the run factor
  function automatic size_sel_t pick_size(input logic gran, input logic [1:0] level,
                                          input logic widen);
    size_sel_t r;
    r.legal = 1'b1;
    r.shift = '0;
    if (gran == GRAN_4K) begin
      case (level)
        2'd3:    r.shift = 6'd12;
        2'd2:    r.shift = 6'd21;
        2'd1:    r.shift = 6'd30;
        default: r.legal = 1'b0;
      endcase
      if (widen) r.shift = r.shift + 6'd4;
    end else begin
      case (level)
        2'd3:    r.shift = 6'd14;
        2'd2:    r.shift = 6'd25;
        default: r.legal = 1'b0;
      endcase
      if (widen) r.shift = r.shift + 6'd5;
    end
    return r;
  endfunction

endpackage

// File: rtl/tlb_fill_decode.sv
module tlb_fill_decode
  import tlb_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter bit HINT_EN = 1'b1
) (
  input  logic            gran,
  input  logic [1:0]      level,
  input  logic            contig,
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] pa,
  output logic            legal,
  output logic [VA_W-1:0] mask,
  output logic [VA_W-1:0] tag,
  output logic [PA_W-1:0] pfn
);

  size_sel_t sel;
  logic      widen;

  always_comb begin
    widen = contig & HINT_EN;
    sel   = pick_size(gran, level, widen);
    legal = sel.legal;
    mask  = (VA_W'(1) << sel.shift) - VA_W'(1);
    tag   = va & ~mask;
    pfn   = pa & ~mask[PA_W-1:0];
  end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter  int ENTRIES = 8,
  parameter  int VA_W    = 48,
  parameter  int PA_W    = 40,
  parameter  int PERM_W  = 4,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           flush,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [VA_W-1:0]                wr_tag,
  input  logic [VA_W-1:0]                wr_mask,
  input  logic [PA_W-1:0]                wr_pfn,
  input  logic [PERM_W-1:0]              wr_perm,
  input  logic [VA_W-1:0]                lk_va,
  output logic [ENTRIES-1:0]             lk_match,
  output logic [ENTRIES-1:0]             same_match,
  output logic [ENTRIES-1:0][PA_W-1:0]   ent_pfn,
  output logic [ENTRIES-1:0][PA_W-1:0]   ent_off,
  output logic [ENTRIES-1:0][PERM_W-1:0] ent_perm
);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VA_W-1:0]   tag_q;
  logic [ENTRIES-1:0][VA_W-1:0]   mask_q;
  logic [ENTRIES-1:0][PA_W-1:0]   pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (flush) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // payload has no reset: it is only observed behind a valid bit
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      mask_q[wr_idx] <= wr_mask;
      pfn_q[wr_idx]  <= wr_pfn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      assign lk_match[i]   = valid_q[i] && ((lk_va & ~mask_q[i]) == tag_q[i]);
      assign same_match[i] = valid_q[i] && (mask_q[i] == wr_mask) && (tag_q[i] == wr_tag);
      assign ent_pfn[i]    = pfn_q[i];
      assign ent_off[i]    = mask_q[i][PA_W-1:0];
      assign ent_perm[i]   = perm_q[i];
    end
  endgenerate

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select #(
  parameter  int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     match,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign any = |match;

endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter  int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst || clear) ptr <= '0;
    else if (advance) ptr <= (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/tlb_unified.sv
module tlb_unified
  import tlb_pkg::*;
#(
  parameter  int VA_W    = 48,
  parameter  int PA_W    = 40,
  parameter  int ENTRIES = 8,
  parameter  int PERM_W  = 4,
  parameter  bit HINT_EN = 1'b1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              fill_req,
  input  logic [VA_W-1:0]   fill_va,
  input  logic [PA_W-1:0]   fill_pa,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_gran16k,
  input  logic [1:0]        fill_level,
  input  logic              fill_contig,
  input  logic              lookup_req,
  input  logic [VA_W-1:0]   lookup_va,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_multi,
  output logic [PA_W-1:0]   resp_pa,
  output logic [PERM_W-1:0] resp_perm
);

  logic                           dec_legal;
  logic [VA_W-1:0]                dec_mask;
  logic [VA_W-1:0]                dec_tag;
  logic [PA_W-1:0]                dec_pfn;
  logic [ENTRIES-1:0]             lk_match;
  logic [ENTRIES-1:0]             same_match;
  logic [ENTRIES-1:0][PA_W-1:0]   ent_pfn;
  logic [ENTRIES-1:0][PA_W-1:0]   ent_off;
  logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;
  logic                           lk_any;
  logic [IDX_W-1:0]               lk_idx;
  logic                           lk_many;
  logic                           same_any;
  logic [IDX_W-1:0]               same_idx;
  logic [IDX_W-1:0]               vic_ptr;
  logic                           fill_go;
  logic [IDX_W-1:0]               wr_idx;

  tlb_fill_decode #(.VA_W(VA_W), .PA_W(PA_W), .HINT_EN(HINT_EN)) u_decode (
    .gran   (fill_gran16k),
    .level  (fill_level),
    .contig (fill_contig),
    .va     (fill_va),
    .pa     (fill_pa),
    .legal  (dec_legal),
    .mask   (dec_mask),
    .tag    (dec_tag),
    .pfn    (dec_pfn)
  );

  assign fill_go = fill_req & dec_legal & ~flush;
  assign wr_idx  = same_any ? same_idx : vic_ptr;

  tlb_entry_array #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PERM_W(PERM_W)) u_array (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .wr_en      (fill_go),
    .wr_idx     (wr_idx),
    .wr_tag     (dec_tag),
    .wr_mask    (dec_mask),
    .wr_pfn     (dec_pfn),
    .wr_perm    (fill_perm),
    .lk_va      (lookup_va),
    .lk_match   (lk_match),
    .same_match (same_match),
    .ent_pfn    (ent_pfn),
    .ent_off    (ent_off),
    .ent_perm   (ent_perm)
  );

  tlb_hit_select #(.N(ENTRIES)) u_lk_sel (
    .match (lk_match),
    .any   (lk_any),
    .idx   (lk_idx)
  );

  tlb_hit_select #(.N(ENTRIES)) u_same_sel (
    .match (same_match),
    .any   (same_any),
    .idx   (same_idx)
  );

  assign lk_many = $countones(lk_match) > 1;

  tlb_victim_ptr #(.N(ENTRIES)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .clear   (flush),
    .advance (fill_go & ~same_any),
    .ptr     (vic_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_multi <= 1'b0;
    end else begin
      resp_valid <= lookup_req;
      resp_hit   <= lookup_req & lk_any;
      resp_multi <= lookup_req & lk_many;
    end
  end

  always_ff @(posedge clk) begin
    resp_pa   <= ent_pfn[lk_idx] | (lookup_va[PA_W-1:0] & ent_off[lk_idx]);
    resp_perm <= ent_perm[lk_idx];
  end

endmodule

// File: rtl/tlb_unified_chk.sv
module tlb_unified_chk (
  input logic        clk,
  input logic        rst,
  input logic        flush,
  input logic        lookup_req,
  input logic        resp_valid,
  input logic        resp_hit,
  input logic        resp_multi,
  input logic [11:0] va_low,
  input logic [11:0] pa_low
);

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) lookup_req |=> resp_valid); // R2
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (rst) !lookup_req |=> !resp_valid); // R2
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (rst) !resp_valid |-> (!resp_hit && !resp_multi)); // R2
  AST_MULTI_WITH_HIT: assert property (@(posedge clk) disable iff (rst) resp_multi |-> resp_hit); // R10
  AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (rst) resp_hit |-> (pa_low == $past(va_low))); // R3
  AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst) ($past(flush, 2) && $past(lookup_req)) |-> !resp_hit); // R12

endmodule

bind tlb_unified tlb_unified_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .lookup_req (lookup_req),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_multi (resp_multi),
  .va_low     (lookup_va[11:0]),
  .pa_low     (resp_pa[11:0])
);

// File: tb/tlb_unified_bench.sv
module tlb_unified_bench;

  localparam int VA_W = 48;
  localparam int PA_W = 40;
  localparam int N    = 8;
  localparam int PW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic            flush = 0, fill_req = 0, fill_gran16k = 0, fill_contig = 0, lookup_req = 0;
  logic [VA_W-1:0] fill_va = '0, lookup_va = '0;
  logic [PA_W-1:0] fill_pa = '0;
  logic [PW-1:0]   fill_perm = '0;
  logic [1:0]      fill_level = '0;

  logic            resp_valid, resp_hit, resp_multi;
  logic [PA_W-1:0] resp_pa;
  logic [PW-1:0]   resp_perm;
  logic            nh_valid, nh_hit, nh_multi;
  logic [PA_W-1:0] nh_pa;
  logic [PW-1:0]   nh_perm;

  tlb_unified #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(N), .PERM_W(PW), .HINT_EN(1'b1)) u_tlb_unified (
    .clk(clk), .rst(rst), .flush(flush), .fill_req(fill_req), .fill_va(fill_va), .fill_pa(fill_pa),
    .fill_perm(fill_perm), .fill_gran16k(fill_gran16k), .fill_level(fill_level), .fill_contig(fill_contig),
    .lookup_req(lookup_req), .lookup_va(lookup_va), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_multi(resp_multi), .resp_pa(resp_pa), .resp_perm(resp_perm));

  tlb_unified #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(N), .PERM_W(PW), .HINT_EN(1'b0)) u_tlb_unified_nohint (
    .clk(clk), .rst(rst), .flush(flush), .fill_req(fill_req), .fill_va(fill_va), .fill_pa(fill_pa),
    .fill_perm(fill_perm), .fill_gran16k(fill_gran16k), .fill_level(fill_level), .fill_contig(fill_contig),
    .lookup_req(lookup_req), .lookup_va(lookup_va), .resp_valid(nh_valid), .resp_hit(nh_hit),
    .resp_multi(nh_multi), .resp_pa(nh_pa), .resp_perm(nh_perm));

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;
  bit    done = 0;

  // behavioural reference: slot contents as byte base, byte size, frame
  bit          m_v[N];
  logic [63:0] m_base[N];
  logic [63:0] m_size[N];
  logic [63:0] m_pfn[N];
  logic [PW-1:0] m_perm[N];
  int          m_ptr = 0;
  bit          e_valid = 0, e_hit = 0, e_multi = 0;
  logic [63:0] e_pa = '0;
  logic [PW-1:0] e_perm = '0;

  function automatic logic [63:0] ref_size(input logic g16, input logic [1:0] lvl, input logic hint);
    logic [63:0] s;
    s = 64'd0;
    if (!g16) begin
      case (lvl)
        2'd3: s = 64'h1000;
        2'd2: s = 64'h20_0000;
        2'd1: s = 64'h4000_0000;
        default: s = 64'd0;
      endcase
      if (hint) s = s * 16;
    end else begin
      case (lvl)
        2'd3: s = 64'h4000;
        2'd2: s = 64'h200_0000;
        default: s = 64'd0;
      endcase
      if (hint) s = s * 32;
    end
    return s;
  endfunction

  always @(posedge clk) begin : model
    logic [63:0] va, sz, base, pfn;
    int hits, slot;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_size[i] = 64'd1; end
      m_ptr = 0; e_valid = 0; e_hit = 0; e_multi = 0;
    end else begin
      va = 64'(lookup_va);
      hits = 0;
      e_valid = lookup_req;
      if (lookup_req) begin
        for (int i = 0; i < N; i++) begin
          if (m_v[i] && (va - (va % m_size[i])) == m_base[i]) begin
            hits++;
            if (hits == 1) begin
              e_pa = m_pfn[i] + (va % m_size[i]);
              e_perm = m_perm[i];
            end
          end
        end
      end
      e_hit = hits > 0;
      e_multi = hits > 1;
      if (flush) begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_ptr = 0;
      end else if (fill_req) begin
        sz = ref_size(fill_gran16k, fill_level, fill_contig);
        if (sz != 0) begin
          base = 64'(fill_va) - (64'(fill_va) % sz);
          pfn  = 64'(fill_pa) - (64'(fill_pa) % sz);
          slot = -1;
          for (int i = 0; i < N; i++)
            if (slot < 0 && m_v[i] && m_base[i] == base && m_size[i] == sz) slot = i;
          if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N; end
          m_v[slot] = 1; m_base[slot] = base; m_size[slot] = sz;
          m_pfn[slot] = pfn; m_perm[slot] = fill_perm;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (resp_valid !== e_valid || resp_hit !== e_hit || resp_multi !== e_multi ||
          (e_hit && (resp_pa !== e_pa[PA_W-1:0] || resp_perm !== e_perm))) begin
        errors++;
        $display("FAIL %s: valid/hit/multi/pa/perm actual %0b %0b %0b %h %h expected %0b %0b %0b %h %h",
                 cur_req, resp_valid, resp_hit, resp_multi, resp_pa, resp_perm,
                 e_valid, e_hit, e_multi, e_pa[PA_W-1:0], e_perm);
      end
    end
  end

  task automatic clear_in();
    flush = 0; fill_req = 0; lookup_req = 0; fill_contig = 0;
  endtask

  task automatic idle();
    @(negedge clk); clear_in();
  endtask

  task automatic do_fill(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa, input logic [PW-1:0] perm,
                         input logic g16, input logic [1:0] lvl, input logic hint);
    @(negedge clk); clear_in();
    fill_req = 1; fill_va = va; fill_pa = pa; fill_perm = perm;
    fill_gran16k = g16; fill_level = lvl; fill_contig = hint;
  endtask

  task automatic do_look(input logic [VA_W-1:0] va);
    @(negedge clk); clear_in();
    lookup_req = 1; lookup_va = va;
  endtask

  task automatic do_flush(input logic with_fill);
    @(negedge clk); clear_in();
    flush = 1;
    if (with_fill) begin
      fill_req = 1; fill_va = 48'h55_0000; fill_pa = 40'h66_0000; fill_perm = 4'h3;
      fill_gran16k = 0; fill_level = 2'd3;
    end
  endtask

  task automatic nh_check(input string req, input logic exp_hit, input logic [PA_W-1:0] exp_pa);
    checks++;
    if (nh_hit !== exp_hit || (exp_hit && nh_pa !== exp_pa)) begin
      errors++;
      $display("FAIL %s: hint-off hit/pa actual %0b %h expected %0b %h", req, nh_hit, nh_pa, exp_hit, exp_pa);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; cmp_on = 1;

    cur_req = "R1"; do_look(48'h0); do_look(48'h1234_5000); idle();

    cur_req = "R3";
    do_fill(48'h1234_5000, 40'h00_ABCD_E000, 4'h1, 0, 2'd3, 0);
    do_look(48'h1234_5ABC); do_look(48'h1234_6000);
    do_fill(48'h8020_0000, 40'h3_0060_0000, 4'h2, 0, 2'd2, 0);
    do_look(48'h803F_FFF8); do_look(48'h8040_0000);
    do_fill(48'h40_0000_0000, 40'h80_0000_0000, 4'h4, 0, 2'd1, 0);
    do_look(48'h40_3FFF_FFFF); do_look(48'h40_4000_0000);

    cur_req = "R4";
    do_fill(48'h5000_8000, 40'h1234_C000, 4'h5, 1, 2'd3, 0);
    do_look(48'h5000_BFFF); do_look(48'h5000_C000);
    do_fill(48'h6200_0000, 40'h7E_0200_0000, 4'h6, 1, 2'd2, 0);
    do_look(48'h63FF_FFFF); do_look(48'h6400_0000);

    cur_req = "R12"; do_flush(0); do_look(48'h1234_5ABC); idle();

    cur_req = "R5";
    do_fill(48'h13_7000, 40'h9_8765_3000, 4'h8, 0, 2'd3, 1);
    do_look(48'h13_F00C); idle();
    nh_check("R7", 1'b0, '0);
    do_look(48'h13_7ABC); idle();
    nh_check("R7", 1'b1, 40'h9_8765_3ABC);
    do_look(48'h14_0000);
    do_fill(48'h1_0060_0000, 40'h2_0000_0000, 4'h9, 0, 2'd2, 1);
    do_look(48'h1_01FF_FFF0); do_look(48'h1_0200_0000);

    cur_req = "R6";
    do_fill(48'h20_4200_0000, 40'h11_4600_0000, 4'hA, 1, 2'd2, 1);
    do_look(48'h20_7FFF_FFFC); do_look(48'h20_8000_0000); do_look(48'h20_4000_0010);

    cur_req = "R8";
    do_fill(48'h30_0000_0000, 40'h1_0000_0000, 4'hB, 1, 2'd1, 0);
    do_fill(48'h31_0000_0000, 40'h1_0000_0000, 4'hB, 0, 2'd0, 0);
    do_look(48'h30_0000_0000); do_look(48'h31_0000_0000);

    cur_req = "R9";
    do_fill(48'h13_2000, 40'h9_8765_0000, 4'h7, 0, 2'd3, 1);
    do_look(48'h13_1234);

    cur_req = "R10";
    do_fill(48'h20_5000_0000, 40'h0_0001_0000, 4'hC, 0, 2'd3, 0);
    do_look(48'h20_5000_0ABC); do_look(48'h20_5000_1ABC);

    cur_req = "R13";
    @(negedge clk); clear_in();
    fill_req = 1; fill_va = 48'h7000_0000; fill_pa = 40'h4_4444_4000; fill_perm = 4'hD;
    fill_gran16k = 0; fill_level = 2'd3; fill_contig = 0;
    lookup_req = 1; lookup_va = 48'h7000_0123;
    do_look(48'h7000_0123);

    cur_req = "R11";
    do_flush(0);
    for (int i = 0; i < N + 1; i++)
      do_fill(48'h10_0000 + 48'(i) * 48'h1000, 40'h20_0000 + 40'(i) * 40'h1000, PW'(i), 0, 2'd3, 0);
    do_look(48'h10_0010); do_look(48'h10_1010); do_look(48'h10_8010);

    cur_req = "R12";
    do_flush(1); do_look(48'h55_0000); do_look(48'h10_1010); idle();

    cur_req = "R2"; idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule